// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical memory address. The segment value is shifted left by four bits and the offset is added. Any carry beyond the top address bit is dropped. Because the shift is only four bits, segments may start on any 16-byte boundary and may overlap.

Four segment registers are held inside the block: code, data, extra and stack. Each can be written through a load port. The requester gives an access kind and, for data accesses, the base register the offset was formed from. From these the block picks the segment by default. A segment override may replace that choice where it is allowed.

For string transfers the block keeps a source index and a destination index. The source index is relative to the data segment and the destination index to the extra segment. Each pointer moves by one element after it is used, upward or downward as a direction input sets it. The address result is registered and appears one clock after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: For every request, `phys_addr` equals (segment value × 16 + offset) modulo 2^20, with the carry out of bit 19 discarded. Examples: 1234h:0017h gives 12357h, and FFFFh:0010h gives 00000h.
- R2: `addr_valid` is high in exactly the cycle after a cycle with `req_valid` high, and `phys_addr` is updated at that same time. In a cycle without a request, `addr_valid` is low in the following cycle and `phys_addr` keeps its value.
- R3: After reset, `addr_valid`, `phys_addr`, all four segment registers, `src_idx` and `dst_idx` are zero.
- R4: A fetch (`req_kind`=0) always uses the code segment, with `req_offset` as the offset, and it ignores any override.
- R5: A data access (`req_kind`=1) with no override uses the stack segment when `req_base` is 2 (base pointer) or 3 (stack pointer). It uses the data segment when `req_base` is 0 (none) or 1 (base register).
- R6: When `ovr_valid` is high, `ovr_sel` chooses the segment for data accesses and for string-source accesses. The encoding is 0 code, 1 data, 2 extra, 3 stack.
- R7: A string-source access (`req_kind`=2) uses `src_idx` as its offset and the data segment by default. A string-destination access (`req_kind`=3) uses `dst_idx` as its offset and always the extra segment; it ignores any override. Both kinds ignore `req_offset`.
- R8: After a string access, the index it used changes by 1 when `elem_word`=0 and by 2 when `elem_word`=1. It increments when `dir_down`=0 and decrements when `dir_down`=1, and it wraps within 16 bits. The other index is unchanged.
- R9: `seg_wr_en` writes `seg_wr_data` into the register named by `seg_wr_sel` (same encoding as R6). A request in the same cycle still sees the old value; requests from the next cycle see the new one.
- R10: `idx_wr_en` loads `idx_wr_data` into `src_idx` (`idx_wr_sel`=0) or `dst_idx` (`idx_wr_sel`=1). The new value is visible the next cycle. A load takes priority over a string step of the same pointer in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | Segment value to write |
| idx_wr_en | input | 1 | Index pointer load strobe |
| idx_wr_sel | input | 1 | 0 source index, 1 destination index |
| idx_wr_data | input | 16 | Index value to load |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | 0 fetch, 1 data, 2 string source, 3 string destination |
| req_base | input | 2 | 0 none, 1 base register, 2 base pointer, 3 stack pointer |
| req_offset | input | 16 | Offset for fetch and data accesses |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment |
| elem_word | input | 1 | String element is a word (step 2) rather than a byte |
| dir_down | input | 1 | String pointers decrement when high |
| addr_valid | output | 1 | Registered address is new this cycle |
| phys_addr | output | 20 | Registered physical address |
| src_idx | output | 16 | Current source index |
| dst_idx | output | 16 | Current destination index |

## Verification
A corrupted segment register has no effect until some access selects it. It then shows as a wrong `phys_addr` one clock after that access, and every access that picks the same segment shows it again. A wrong index pointer shows at once on `src_idx` or `dst_idx`. It also shows in the address of the next string access that uses it, so stepping, wrap-around and load priority are each observed within a cycle. A wrong choice of default segment or override is visible only in the upper address bits. For that reason the bench loads every segment with a distinct value before it checks segment selection.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int NUM_SEGS = 4;

    typedef enum logic [1:0] {
        KIND_FETCH   = 2'd0,
        KIND_DATA    = 2'd1,
        KIND_STR_SRC = 2'd2,
        KIND_STR_DST = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BREG = 2'd1,
        BASE_BPTR = 2'd2,
        BASE_SPTR = 2'd3
    } base_e;

endpackage

// File: rtl/seg_file.sv
module seg_file #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [SEG_W-1:0]      wr_data,
    output logic [NSEG*SEG_W-1:0] seg_flat
);

    logic [NSEG*SEG_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int g = 0; g < NSEG; g++) begin
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                bank_d[g*SEG_W +: SEG_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign seg_flat = bank_q;

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  acc_kind_e kind,
    input  base_e     base,
    input  logic      ovr_valid,
    input  seg_id_e   ovr_sel,
    output seg_id_e   seg_id,
    output logic      use_src,
    output logic      use_dst
);

    seg_id_e data_default;

    always_comb begin
        use_src = (kind == KIND_STR_SRC);
        use_dst = (kind == KIND_STR_DST);
        data_default = ((base == BASE_BPTR) || (base == BASE_SPTR)) ? SEG_STACK : SEG_DATA;
        unique case (kind)
            KIND_FETCH:   seg_id = SEG_CODE;
            KIND_STR_DST: seg_id = SEG_EXTRA;
            KIND_STR_SRC: seg_id = ovr_valid ? ovr_sel : SEG_DATA;
            default:      seg_id = ovr_valid ? ovr_sel : data_default;
        endcase
    end

endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base_ext, off_ext;

    always_comb begin
        base_ext = ADDR_W'(seg_val) << SHIFT;
        off_ext  = ADDR_W'(offset);
        addr     = base_ext + off_ext;
    end

endmodule

// File: rtl/idx_unit.sv
module idx_unit #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_data,
    input  logic             step_src,
    input  logic             step_dst,
    input  logic             elem_word,
    input  logic             dir_down,
    output logic [IDX_W-1:0] src_idx,
    output logic [IDX_W-1:0] dst_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
    } idx_t;

    idx_t idx_d, idx_q;
    logic [IDX_W-1:0] step;

    always_comb begin
        step  = elem_word ? IDX_W'(2) : IDX_W'(1);
        idx_d = idx_q;
        if (step_src) begin
            idx_d.src = dir_down ? idx_q.src - step : idx_q.src + step;
        end
        if (step_dst) begin
            idx_d.dst = dir_down ? idx_q.dst - step : idx_q.dst + step;
        end
        if (wr_en && !wr_sel) begin
            idx_d.src = wr_data;
        end
        if (wr_en && wr_sel) begin
            idx_d.dst = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign src_idx = idx_q.src;
    assign dst_idx = idx_q.dst;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int SEL_W  = $clog2(NUM_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              idx_wr_en,
    input  logic              idx_wr_sel,
    input  logic [OFF_W-1:0]  idx_wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              ovr_valid,
    input  logic [SEL_W-1:0]  ovr_sel,
    input  logic              elem_word,
    input  logic              dir_down,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [OFF_W-1:0]  src_idx,
    output logic [OFF_W-1:0]  dst_idx
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t                      out_d, out_q;
    logic [NUM_SEGS*SEG_W-1:0] seg_flat;
    seg_id_e                   seg_id;
    logic                      use_src, use_dst;
    logic [SEG_W-1:0]          seg_val;
    logic [OFF_W-1:0]          off_c;
    logic [ADDR_W-1:0]         addr_c;

    seg_file #(.SEG_W(SEG_W), .NSEG(NUM_SEGS)) seg_file_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (seg_wr_en),
        .wr_sel   (seg_wr_sel),
        .wr_data  (seg_wr_data),
        .seg_flat (seg_flat)
    );

    seg_select seg_select_i (
        .kind      (acc_kind_e'(req_kind)),
        .base      (base_e'(req_base)),
        .ovr_valid (ovr_valid),
        .ovr_sel   (seg_id_e'(ovr_sel)),
        .seg_id    (seg_id),
        .use_src   (use_src),
        .use_dst   (use_dst)
    );

    idx_unit #(.IDX_W(OFF_W)) idx_unit_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (idx_wr_en),
        .wr_sel    (idx_wr_sel),
        .wr_data   (idx_wr_data),
        .step_src  (req_valid && use_src),
        .step_dst  (req_valid && use_dst),
        .elem_word (elem_word),
        .dir_down  (dir_down),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx)
    );

    always_comb begin
        seg_val = seg_flat[int'(seg_id)*SEG_W +: SEG_W];
        if (use_src) begin
            off_c = src_idx;
        end else if (use_dst) begin
            off_c = dst_idx;
        end else begin
            off_c = req_offset;
        end
    end

    addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) addr_adder_i (
        .seg_val (seg_val),
        .offset  (off_c),
        .addr    (addr_c)
    );

    always_comb begin
        out_d.valid = req_valid;
        out_d.addr  = req_valid ? addr_c : out_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_valid = out_q.valid;
    assign phys_addr  = out_q.addr;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20,
    parameter int NSEG   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  seg_wr_en,
    input logic [1:0]            seg_wr_sel,
    input logic [SEG_W-1:0]      seg_wr_data,
    input logic                  idx_wr_en,
    input logic                  idx_wr_sel,
    input logic [OFF_W-1:0]      idx_wr_data,
    input logic                  req_valid,
    input logic [1:0]            req_kind,
    input logic [OFF_W-1:0]      req_offset,
    input logic                  elem_word,
    input logic                  dir_down,
    input logic                  addr_valid,
    input logic [ADDR_W-1:0]     phys_addr,
    input logic [OFF_W-1:0]      src_idx,
    input logic [OFF_W-1:0]      dst_idx,
    input logic [NSEG*SEG_W-1:0] seg_flat
);

    logic [ADDR_W-1:0] fetch_exp;
    logic [OFF_W-1:0]  step, src_next, dst_next;
    logic [1:0]        wr_sel_q;
    logic [SEG_W-1:0]  seg_at_prev_sel;

    always_comb begin
        fetch_exp = (ADDR_W'(seg_flat[SEG_W-1:0]) << SHIFT) + ADDR_W'(req_offset);
        step      = elem_word ? OFF_W'(2) : OFF_W'(1);
        src_next  = dir_down ? src_idx - step : src_idx + step;
        dst_next  = dir_down ? dst_idx - step : dst_idx + step;
        seg_at_prev_sel = seg_flat[int'(wr_sel_q)*SEG_W +: SEG_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_sel_q <= '0;
        end else begin
            wr_sel_q <= seg_wr_sel;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && $stable(phys_addr)));

    a_r4_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> (phys_addr == $past(fetch_exp)));

    a_r8_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2 && !(idx_wr_en && !idx_wr_sel))
        |=> (src_idx == $past(src_next)));

    a_r8_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3 && !(idx_wr_en && idx_wr_sel))
        |=> (dst_idx == $past(dst_next)));

    a_r8_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid && req_kind == 2'd2) && !(idx_wr_en && !idx_wr_sel))
        |=> $stable(src_idx));

    a_r9_seg_load: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_en |=> (seg_at_prev_sel == $past(seg_wr_data)));

    a_r10_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr_en && !idx_wr_sel) |=> (src_idx == $past(idx_wr_data)));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W), .NSEG(4)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_wr_en   (seg_wr_en),
    .seg_wr_sel  (seg_wr_sel),
    .seg_wr_data (seg_wr_data),
    .idx_wr_en   (idx_wr_en),
    .idx_wr_sel  (idx_wr_sel),
    .idx_wr_data (idx_wr_data),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_offset  (req_offset),
    .elem_word   (elem_word),
    .dir_down    (dir_down),
    .addr_valid  (addr_valid),
    .phys_addr   (phys_addr),
    .src_idx     (src_idx),
    .dst_idx     (dst_idx),
    .seg_flat    (seg_flat)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        idx_wr_en = 1'b0;
    logic        idx_wr_sel = 1'b0;
    logic [15:0] idx_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_base = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        elem_word = 1'b0;
    logic        dir_down = 1'b0;
    logic        addr_valid;
    logic [19:0] phys_addr;
    logic [15:0] src_idx, dst_idx;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .idx_wr_en(idx_wr_en), .idx_wr_sel(idx_wr_sel), .idx_wr_data(idx_wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_base(req_base),
        .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .elem_word(elem_word), .dir_down(dir_down),
        .addr_valid(addr_valid), .phys_addr(phys_addr),
        .src_idx(src_idx), .dst_idx(dst_idx)
    );

    function automatic logic [19:0] lin(input logic [15:0] seg, input logic [15:0] off);
        logic [20:0] s;
        s = {5'd0, seg} * 21'd16 + {5'd0, off};
        return s[19:0];
    endfunction

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_seg(input logic [1:0] sel, input logic [15:0] val);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic load_idx(input logic sel, input logic [15:0] val);
        idx_wr_en = 1'b1; idx_wr_sel = sel; idx_wr_data = val;
        @(negedge clk);
        idx_wr_en = 1'b0;
    endtask

    task automatic access(input logic [1:0] kind, input logic [1:0] base, input logic [15:0] off,
                          input logic ov, input logic [1:0] os, input logic word, input logic dn);
        req_valid = 1'b1; req_kind = kind; req_base = base; req_offset = off;
        ovr_valid = ov; ovr_sel = os; elem_word = word; dir_down = dn;
        @(negedge clk);
        req_valid = 1'b0; ovr_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R3 addr_valid", 20'(addr_valid), 20'd0);
        chk("R3 phys_addr", phys_addr, 20'd0);
        chk("R3 src_idx", 20'(src_idx), 20'd0);
        chk("R3 dst_idx", 20'(dst_idx), 20'd0);
        access(2'd1, 2'd0, 16'h0040, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R3 data segment zero", phys_addr, 20'h00040);
    endtask

    task automatic t_fetch();
        load_seg(2'd0, 16'h1234);
        load_seg(2'd3, 16'hF000);
        access(2'd0, 2'd0, 16'h0017, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R1 R4 fetch 1234:0017", phys_addr, 20'h12357);
        chk("R2 valid after request", 20'(addr_valid), 20'd1);
        access(2'd0, 2'd3, 16'h0100, 1'b1, 2'd3, 1'b0, 1'b0);
        chk("R4 fetch ignores override", phys_addr, lin(16'h1234, 16'h0100));
    endtask

    task automatic t_wrap();
        load_seg(2'd0, 16'hFFFF);
        access(2'd0, 2'd0, 16'h0010, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R1 wrap to zero", phys_addr, 20'h00000);
        access(2'd0, 2'd0, 16'hFFFF, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R1 wrap high offset", phys_addr, 20'h0FFEF);
    endtask

    task automatic t_idle();
        access(2'd0, 2'd0, 16'h0005, 1'b0, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 idle valid low", 20'(addr_valid), 20'd0);
        chk("R2 idle address held", phys_addr, lin(16'hFFFF, 16'h0005));
    endtask

    task automatic t_defaults();
        load_seg(2'd0, 16'h1000);
        load_seg(2'd1, 16'h2000);
        load_seg(2'd2, 16'h4000);
        load_seg(2'd3, 16'h3000);
        access(2'd1, 2'd0, 16'h0123, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R5 no base -> data", phys_addr, 20'h20123);
        access(2'd1, 2'd1, 16'h0456, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R5 base reg -> data", phys_addr, 20'h20456);
        access(2'd1, 2'd2, 16'h0789, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R5 base ptr -> stack", phys_addr, 20'h30789);
        access(2'd1, 2'd3, 16'hFFF0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R5 stack ptr -> stack", phys_addr, 20'h3FFF0);
    endtask

    task automatic t_override();
        access(2'd1, 2'd2, 16'h0010, 1'b1, 2'd2, 1'b0, 1'b0);
        chk("R6 data override extra", phys_addr, 20'h40010);
        access(2'd1, 2'd0, 16'h0020, 1'b1, 2'd0, 1'b0, 1'b0);
        chk("R6 data override code", phys_addr, 20'h10020);
        load_idx(1'b0, 16'h0050);
        access(2'd2, 2'd0, 16'h9999, 1'b1, 2'd3, 1'b0, 1'b0);
        chk("R6 string source override stack", phys_addr, 20'h30050);
    endtask

    task automatic t_string();
        load_idx(1'b0, 16'h0100);
        load_idx(1'b1, 16'h0200);
        access(2'd2, 2'd0, 16'hABCD, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R7 source address", phys_addr, 20'h20100);
        chk("R8 source +1", 20'(src_idx), 20'h00101);
        chk("R8 dest unchanged", 20'(dst_idx), 20'h00200);
        access(2'd3, 2'd0, 16'hABCD, 1'b1, 2'd1, 1'b1, 1'b1);
        chk("R7 dest extra ignores override", phys_addr, 20'h40200);
        chk("R8 dest -2", 20'(dst_idx), 20'h001FE);
        chk("R8 source unchanged", 20'(src_idx), 20'h00101);
        access(2'd2, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R8 source +2", 20'(src_idx), 20'h00103);
        load_idx(1'b0, 16'hFFFF);
        access(2'd2, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R8 source wrap up", 20'(src_idx), 20'h00001);
        load_idx(1'b1, 16'h0000);
        access(2'd3, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R8 dest wrap down", 20'(dst_idx), 20'h0FFFF);
        access(2'd3, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R7 dest uses stepped index", phys_addr, lin(16'h4000, 16'hFFFF));
    endtask

    task automatic t_same_cycle();
        seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h5000;
        access(2'd1, 2'd0, 16'h0001, 1'b0, 2'd0, 1'b0, 1'b0);
        seg_wr_en = 1'b0;
        chk("R9 same-cycle sees old", phys_addr, 20'h20001);
        access(2'd1, 2'd0, 16'h0001, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R9 next cycle sees new", phys_addr, 20'h50001);
        load_idx(1'b0, 16'h0300);
        idx_wr_en = 1'b1; idx_wr_sel = 1'b0; idx_wr_data = 16'h0777;
        access(2'd2, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0);
        idx_wr_en = 1'b0;
        chk("R10 load wins over step", 20'(src_idx), 20'h00777);
        chk("R10 address used old index", phys_addr, 20'h50300);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fetch();
        t_wrap();
        t_idle();
        t_defaults();
        t_override();
        t_string();
        t_same_cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule